// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

This block is one programmable logic cell of an embedded reconfigurable fabric. It pairs a sixteen-entry lookup table with two user flip-flops. A two-bit operating mode decides what the flip-flops capture. A two-bit output selector decides what the combinational output shows. The table contents, the mode and the selector all sit in a twenty-bit configuration register. That register is loaded serially: the chain input of one cell is wired to the chain output of the cell before it.

In normal operation the chain enable is low and the cell evaluates its four logic inputs every cycle. To program a column of cells, the chain enable is raised and one bit per clock is shifted through every cell in turn. The user flip-flops keep their value while this happens. The user reset is synchronous and active low. It clears only the user flip-flops and never touches the configuration.

Top module: `lutCell`

## Requirements
- R1: With the config word's bits 15:0 as table T and no registered output selected, the combinational output in modes 0 (combinational), 1 (registered) and 3 (direct) equals T[idx], where idx = {lutIn[3], lutIn[2], lutIn[1], lutIn[0]} and lutIn[3] is the most significant bit.
- R2: In mode 0 (mode field value 0) neither user flip-flop changes at a clock edge.
- R3: In mode 1 (value 1), regOut[0] captures T[idx] at each clock edge while regOut[1] holds.
- R4: In mode 2 (value 2) the table acts as two 3-input tables: regOut[0] captures T[lutIn[2:0]] and regOut[1] captures T[8 + lutIn[2:0]]. The combinational output shows the low result when selector bit 0 is 0 and the high result when it is 1.
- R5: In mode 3 (value 3), regOut[0] captures dIn and regOut[1] captures T[idx] at each clock edge.
- R6: When selector bit 1 is set, the combinational output equals regOut[0] in any mode.
- R7: The config word is laid out as table in bits 15:0, mode in bits 17:16 and selector in bits 19:18. With cfgEn high, each clock shifts cfgIn into bit 0 and moves every bit up by one, so a word is loaded by sending bit 19 first.
- R8: cfgOut always shows bit 19 of the config register, so during a new load the previous word leaves the cell most significant bit first.
- R9: While cfgEn is high, both user flip-flops hold their value.
- R10: rstN low at a clock edge clears both user flip-flops to 0 at that edge.
- R11: The config register changes only while cfgEn is high. Neither the user reset nor normal operation alters it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for user and configuration logic |
| rstN | input | 1 | Synchronous active-low reset of the user flip-flops |
| lutIn | input | 4 | Logic inputs, bit 3 most significant table index bit |
| dIn | input | 1 | External data captured directly in mode 3 |
| combOut | output | 1 | Combinational result or registered value per selector |
| regOut | output | 2 | User flip-flop outputs |
| cfgIn | input | 1 | Serial configuration data in |
| cfgEn | input | 1 | Shift enable for the configuration chain |
| cfgOut | output | 1 | Serial configuration data out to the next cell |

## Verification
The bench builds the cell with the default package values: four table inputs, a two-bit mode and a two-bit selector, which gives a twenty-bit chain. At this size every one of the sixteen input combinations can be swept in each mode and with each selector setting, and a full chain word can be shifted in and compared bit by bit. Shifting a new word in brings the previous word out on cfgOut while the flip-flops hold non-zero state. Running the cell again after a reset shows that the configuration survived.

// File: rtl/lutCellPkg.sv
package lutCellPkg;
  parameter int LUT_K = 4;
  localparam int TABLE_W = 1 << LUT_K;
  localparam int HALF_W = TABLE_W / 2;
  localparam int MODE_W = 2;
  localparam int OSEL_W = 2;
  localparam int CFG_W = TABLE_W + MODE_W + OSEL_W;
  localparam int FF_N = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_COMB   = 2'd0,
    MODE_REG    = 2'd1,
    MODE_SPLIT  = 2'd2,
    MODE_DIRECT = 2'd3
  } cellModeE;

  typedef enum logic [1:0] {
    SRC_FULL = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_DIN  = 2'd3
  } ffSrcE;

  typedef struct packed {
    logic [FF_N-1:0]       ffLoad;
    logic [FF_N-1:0][1:0]  ffSrc;
    logic                  combFromFf;
    logic                  combSplit;
    logic                  combHigh;
    logic [TABLE_W-1:0]    lutTable;
  } cellCtrlT;
endpackage

// File: rtl/lutCellCfg.sv
module lutCellCfg
  import lutCellPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgEn,
  input  logic     cfgIn,
  output logic     cfgOut,
  output cellCtrlT ctrl
);
  logic [CFG_W-1:0]  cfgReg;
  logic [OSEL_W-1:0] oSel;
  cellModeE          modeSel;

  // Configuration chain: not reset, only shifted.
  always_ff @(posedge clk) begin
    if (cfgEn) cfgReg <= {cfgReg[CFG_W-2:0], cfgIn};
  end

  assign cfgOut  = cfgReg[CFG_W-1];
  assign modeSel = cellModeE'(cfgReg[TABLE_W +: MODE_W]);
  assign oSel    = cfgReg[TABLE_W+MODE_W +: OSEL_W];

  always_comb begin
    ctrl          = '0;
    ctrl.lutTable = cfgReg[TABLE_W-1:0];
    unique case (modeSel)
      MODE_COMB: ctrl.ffLoad = '0;
      MODE_REG: begin
        ctrl.ffLoad   = 2'b01;
        ctrl.ffSrc[0] = SRC_FULL;
      end
      MODE_SPLIT: begin
        ctrl.ffLoad   = 2'b11;
        ctrl.ffSrc[0] = SRC_LOW;
        ctrl.ffSrc[1] = SRC_HIGH;
      end
      MODE_DIRECT: begin
        ctrl.ffLoad   = 2'b11;
        ctrl.ffSrc[0] = SRC_DIN;
        ctrl.ffSrc[1] = SRC_FULL;
      end
      default: ctrl.ffLoad = '0;
    endcase
    if (cfgEn) ctrl.ffLoad = '0;
    ctrl.combFromFf = oSel[1];
    ctrl.combSplit  = (modeSel == MODE_SPLIT);
    ctrl.combHigh   = oSel[0];
  end

  AST_CFG_SHIFT_IN: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> cfgReg[0] == $past(cfgIn)); // R7
  AST_CFG_PASS_ON: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> cfgOut == $past(cfgReg[CFG_W-2])); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk)
    !cfgEn |=> $stable(cfgReg)); // R11
endmodule

// File: rtl/lutCellDatapath.sv
module lutCellDatapath
  import lutCellPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LUT_K-1:0]  lutIn,
  input  logic              dIn,
  input  cellCtrlT          ctrl,
  output logic              combOut,
  output logic [FF_N-1:0]   ffQ
);
  logic [HALF_W-1:0] tableLo;
  logic [HALF_W-1:0] tableHi;
  logic lutFull;
  logic lutLow;
  logic lutHigh;

  assign tableLo = ctrl.lutTable[HALF_W-1:0];
  assign tableHi = ctrl.lutTable[TABLE_W-1:HALF_W];
  assign lutFull = ctrl.lutTable[lutIn];
  assign lutLow  = tableLo[lutIn[LUT_K-2:0]];
  assign lutHigh = tableHi[lutIn[LUT_K-2:0]];

  for (genvar i = 0; i < FF_N; i++) begin : gFf
    logic dSel;
    logic qReg;
    always_comb begin
      unique case (ctrl.ffSrc[i])
        SRC_FULL: dSel = lutFull;
        SRC_LOW:  dSel = lutLow;
        SRC_HIGH: dSel = lutHigh;
        SRC_DIN:  dSel = dIn;
        default:  dSel = lutFull;
      endcase
    end
    always_ff @(posedge clk) begin
      if (!rstN)               qReg <= 1'b0;
      else if (ctrl.ffLoad[i]) qReg <= dSel;
    end
    assign ffQ[i] = qReg;
  end

  always_comb begin
    if (ctrl.combFromFf)     combOut = ffQ[0];
    else if (ctrl.combSplit) combOut = ctrl.combHigh ? lutHigh : lutLow;
    else                     combOut = lutFull;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> ffQ == '0); // R10
  AST_SPLIT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ffLoad[1] && ctrl.ffSrc[1] == SRC_HIGH) |=> ffQ[1] == $past(lutHigh)); // R4
  AST_DIRECT_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.ffLoad[0] && ctrl.ffSrc[0] == SRC_DIN) |=> ffQ[0] == $past(dIn)); // R5
endmodule

// File: rtl/lutCell.sv
module lutCell
  import lutCellPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LUT_K-1:0]  lutIn,
  input  logic              dIn,
  output logic              combOut,
  output logic [FF_N-1:0]   regOut,
  input  logic              cfgIn,
  input  logic              cfgEn,
  output logic              cfgOut
);
  cellCtrlT ctrl;

  lutCellCfg uCfg (
    .clk    (clk),
    .rstN   (rstN),
    .cfgEn  (cfgEn),
    .cfgIn  (cfgIn),
    .cfgOut (cfgOut),
    .ctrl   (ctrl)
  );

  lutCellDatapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .lutIn   (lutIn),
    .dIn     (dIn),
    .ctrl    (ctrl),
    .combOut (combOut),
    .ffQ     (regOut)
  );

  AST_HOLD_WHILE_CFG: assert property (@(posedge clk) disable iff (!rstN)
    cfgEn |=> $stable(regOut)); // R9
endmodule

// File: tb/lutCell_test.sv
module lutCell_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 20;

  typedef struct {
    logic       comb;
    logic [1:0] regs;
    logic       cfgo;
    bit         chkCfg;
    bit         chkFf;
    string      req;
  } expItemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] lutIn = '0;
  logic dIn = 1'b0;
  logic cfgIn = 1'b0;
  logic cfgEn = 1'b0;
  logic combOut;
  logic [1:0] regOut;
  logic cfgOut;

  expItemT sb[$];
  int nChecks = 0;
  int nErrors = 0;
  logic [CW-1:0] mCfg = '0;
  logic [1:0] mFf = '0;
  bit cfgKnown = 0;
  bit ffKnown = 0;
  int shiftCnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lutCell uut (
    .clk(clk), .rstN(rstN), .lutIn(lutIn), .dIn(dIn),
    .combOut(combOut), .regOut(regOut),
    .cfgIn(cfgIn), .cfgEn(cfgEn), .cfgOut(cfgOut)
  );

  function automatic logic expComb(input logic [3:0] li);
    logic [15:0] t = mCfg[15:0];
    logic [1:0] md = mCfg[17:16];
    logic [1:0] os = mCfg[19:18];
    if (os[1]) return mFf[0];
    if (md == 2'd2) return os[0] ? t[{1'b1, li[2:0]}] : t[{1'b0, li[2:0]}];
    return t[li];
  endfunction

  task automatic cyc(input logic en, input logic ci, input logic [3:0] li,
                     input logic di, input logic rn, input string req);
    expItemT it;
    logic [15:0] t;
    @(negedge clk);
    cfgEn = en; cfgIn = ci; lutIn = li; dIn = di; rstN = rn;
    it.comb = expComb(li);
    it.regs = mFf;
    it.cfgo = mCfg[CW-1];
    it.chkCfg = cfgKnown;
    it.chkFf = ffKnown;
    it.req = req;
    sb.push_back(it);
    t = mCfg[15:0];
    if (!rn) begin
      mFf = '0;
      ffKnown = 1;
    end else if (!en) begin
      case (mCfg[17:16])
        2'd1: mFf[0] = t[li];
        2'd2: begin mFf[0] = t[{1'b0, li[2:0]}]; mFf[1] = t[{1'b1, li[2:0]}]; end
        2'd3: begin mFf[0] = di; mFf[1] = t[li]; end
        default: ;
      endcase
    end
    if (en) begin
      mCfg = {mCfg[CW-2:0], ci};
      shiftCnt++;
      if (shiftCnt >= CW) cfgKnown = 1;
    end
  endtask

  task automatic loadCfg(input logic [1:0] os, input logic [1:0] md,
                         input logic [15:0] t, input string req);
    logic [CW-1:0] w = {os, md, t};
    for (int i = CW-1; i >= 0; i--) cyc(1'b1, w[i], 4'(i), 1'b0, 1'b1, req);
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 16; v++) cyc(1'b0, 1'b0, 4'(v), 1'(v[0] ^ v[2] ^ v[3]), 1'b1, req);
  endtask

  // Monitor: pop expected items between the input change and the next edge
  initial begin
    expItemT e;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (e.chkCfg) begin
          nChecks++;
          if (cfgOut !== e.cfgo) begin
            nErrors++;
            $display("FAIL %s cfgOut actual=%b expected=%b", e.req, cfgOut, e.cfgo);
          end
        end
        if (e.chkFf) begin
          nChecks++;
          if (regOut !== e.regs) begin
            nErrors++;
            $display("FAIL %s regOut actual=%b expected=%b", e.req, regOut, e.regs);
          end
        end
        if (e.chkCfg && e.chkFf) begin
          nChecks++;
          if (combOut !== e.comb) begin
            nErrors++;
            $display("FAIL %s combOut actual=%b expected=%b", e.req, combOut, e.comb);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, "R10");
    loadCfg(2'b00, 2'd0, 16'h6996, "R7");
    sweep("R1/R2");
    loadCfg(2'b00, 2'd1, 16'h8001, "R7/R8");
    sweep("R3");
    loadCfg(2'b00, 2'd2, 16'h96E8, "R7");
    sweep("R4");
    loadCfg(2'b01, 2'd2, 16'h96E8, "R4");
    sweep("R4");
    loadCfg(2'b00, 2'd3, 16'h6996, "R8");
    sweep("R5");
    loadCfg(2'b10, 2'd1, 16'hA5C3, "R9");
    sweep("R6");
    loadCfg(2'b10, 2'd3, 16'h0FF0, "R9/R8");
    sweep("R6/R5");
    cyc(1'b0, 1'b0, 4'h5, 1'b1, 1'b1, "R5");
    cyc(1'b0, 1'b0, 4'h5, 1'b1, 1'b0, "R10");
    cyc(1'b0, 1'b0, 4'h3, 1'b1, 1'b0, "R10");
    sweep("R11");
    loadCfg(2'b00, 2'd0, 16'h1234, "R11");
    sweep("R1");
    repeat (2) @(negedge clk);
    #(CLK_PERIOD/2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule